// File: doc/BRIEF.md
# Transparent Window Address Matcher

This block decides, within one cycle, whether a 32-bit logical address falls inside a transparent-translation window. It holds four 32-bit window registers. Two serve data-space accesses and two serve instruction-space accesses. Each window compares only the top address byte against a base byte, under a per-bit ignore mask. A window can also be restricted to one privilege level, and it can mark its range as write protected.

The lookup port is purely combinational. The caller presents an address, a supervisor flag and a data/instruction select, and reads back a two-bit result in the same cycle.

A separate probe port takes an address and a 3-bit function code. It runs the same lookup and loads a status word on the clock edge that follows the strobe. Neither port has a valid/ready handshake, and neither can apply back-pressure. A lookup is answered in the same cycle, and a probe is accepted on every strobe cycle.

Top module: `tt_matcher`

## Requirements
- R1: A window register whose enable bit (bit 15) is clear never matches, whatever its other fields hold.
- R2: A window matches an address only if every bit of address[31:24] equals the base byte (register bits 31:24). A differing bit is forgiven when the same bit of the mask byte (register bits 23:16) is 1.
- R3: When the privilege-ignore bit (bit 14) is clear, the access's supervisor flag must equal the privilege-select bit (bit 13), or the window does not match. When bit 14 is set, privilege is not checked.
- R4: The result is encoded 0 = no match, 1 = match and 2 = match but write protected. A matching window reports 2 when its write-protect bit (bit 2) is set, and 1 otherwise.
- R5: Within a pair, window 0 is checked first. Window 1 is consulted only when window 0 returns 0, so a write-protected hit in window 0 takes priority over a plain hit in window 1.
- R6: Data accesses (data select = 1) use only the data pair. Instruction accesses use only the instruction pair.
- R7: The probe treats function code bit 2 as the supervisor flag. It treats the access as data space unless function code bits 1:0 equal 2.
- R8: On the edge after a probe strobe, the status word becomes address[31:12] in bits 31:12 and zeros in bits 11:2. Bits 1 (transparent) and 0 (resident) are both set when any window hit, including a write-protected hit. Without a strobe the status word holds its value.
- R9: A synchronous reset clears the enable bit of all four windows and clears the status word.
- R10: Each window has its own write strobe that loads the full 32-bit write data into that window only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dwin0_we | input | 1 | Load data window 0 |
| dwin1_we | input | 1 | Load data window 1 |
| iwin0_we | input | 1 | Load instruction window 0 |
| iwin1_we | input | 1 | Load instruction window 1 |
| wr_data | input | 32 | Value loaded by any window write strobe |
| acc_addr | input | 32 | Lookup address |
| acc_super | input | 1 | Lookup is supervisor |
| acc_data | input | 1 | 1 = data space, 0 = instruction space |
| acc_result | output | 2 | 0 none, 1 match, 2 write-protected match |
| probe_stb | input | 1 | Probe request, one cycle |
| probe_addr | input | 32 | Probe address |
| probe_fc | input | 3 | Probe function code |
| probe_status | output | 32 | Registered probe status word |

## Verification
The bench first targets pair priority. It loads a write-protected window 0 over a plain window 1 on the same range. A design that scanned both windows, or that preferred a plain hit, would report 1 where 2 is expected.

It checks masked top-byte bits separately from unmasked ones. It also drives both privilege levels against a window that requires one level, and against a window that ignores privilege. An inverted mask or an inverted privilege test would therefore flip specific vector results.

Probe cases cover every function-code class, including instruction-user code 2 and the super-data codes. They also cover a write-protected hit, which must still set both low status bits. A decoder that treated code 2 as data, or that dropped protected hits, would show the wrong low bits.

A reset in mid-run is followed by lookups that used to hit. A design that did not clear the enables would keep matching.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    TT_NONE  = 2'd0,
    TT_HIT   = 2'd1,
    TT_WPROT = 2'd2
  } tt_res_e;

  localparam int WIN_W    = 32;
  localparam int BASE_HI  = 31;
  localparam int BASE_LO  = 24;
  localparam int MASK_HI  = 23;
  localparam int MASK_LO  = 16;
  localparam int EN_BIT   = 15;
  localparam int SIGN_BIT = 14;
  localparam int SSEL_BIT = 13;
  localparam int WP_BIT   = 2;
  localparam int ST_T_BIT = 1;
  localparam int ST_R_BIT = 0;
endpackage

// File: rtl/tt_window_cmp.sv
module tt_window_cmp
  import tt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [WIN_W-1:0]  win,
  input  logic [ADDR_W-1:0] addr,
  input  logic              super_acc,
  output tt_res_e           res
);
  localparam int TOP_LO = ADDR_W - 8;

  logic [7:0] diff;
  logic       addr_ok, priv_ok, hit;

  always_comb begin
    diff    = (addr[ADDR_W-1:TOP_LO] ^ win[BASE_HI:BASE_LO]) & ~win[MASK_HI:MASK_LO];
    addr_ok = (diff == 8'd0);
    priv_ok = win[SIGN_BIT] | (win[SSEL_BIT] == super_acc);
    hit     = win[EN_BIT] & addr_ok & priv_ok;
    if (!hit)             res = TT_NONE;
    else if (win[WP_BIT]) res = TT_WPROT;
    else                  res = TT_HIT;
  end

  // R1
  always_comb begin
    if (win[EN_BIT] == 1'b0)
      disabled_no_match_chk: assert (res == TT_NONE);
  end
endmodule

// File: rtl/tt_pair_lookup.sv
module tt_pair_lookup
  import tt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [WIN_W-1:0]  win0,
  input  logic [WIN_W-1:0]  win1,
  input  logic [ADDR_W-1:0] addr,
  input  logic              super_acc,
  output tt_res_e           res
);
  tt_res_e r0, r1;

  tt_window_cmp #(.ADDR_W(ADDR_W)) u_w0 (
    .win(win0), .addr(addr), .super_acc(super_acc), .res(r0));
  tt_window_cmp #(.ADDR_W(ADDR_W)) u_w1 (
    .win(win1), .addr(addr), .super_acc(super_acc), .res(r1));

  always_comb res = (r0 != TT_NONE) ? r0 : r1;

  // R5
  always_comb begin
    if (r0 != TT_NONE)
      first_window_wins_chk: assert (res == r0);
  end
endmodule

// File: rtl/tt_probe.sv
module tt_probe
  import tt_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [ADDR_W-1:0] addr,
  input  tt_res_e           lookup,
  output logic [ADDR_W-1:0] status
);
  logic hit;
  always_comb hit = (lookup != TT_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
    end else if (stb) begin
      status                          <= '0;
      status[ADDR_W-1:PAGE_LSB]       <= addr[ADDR_W-1:PAGE_LSB];
      status[ST_T_BIT]                <= hit;
      status[ST_R_BIT]                <= hit;
    end
  end

  // R8
  page_bits_loaded_chk: assert property (@(posedge clk) disable iff (rst)
    stb |=> status[ADDR_W-1:PAGE_LSB] == $past(addr[ADDR_W-1:PAGE_LSB]));
  // R8
  status_held_chk: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(status));
  // R8
  tr_bits_equal_chk: assert property (@(posedge clk) disable iff (rst)
    status[ST_T_BIT] == status[ST_R_BIT]);
  // R9
  reset_clears_status_chk: assert property (@(posedge clk)
    rst |=> status == '0);
endmodule

// File: rtl/tt_matcher.sv
module tt_matcher
  import tt_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 12,
  parameter int FC_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dwin0_we,
  input  logic              dwin1_we,
  input  logic              iwin0_we,
  input  logic              iwin1_we,
  input  logic [WIN_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_super,
  input  logic              acc_data,
  output logic [1:0]        acc_result,
  input  logic              probe_stb,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic [FC_W-1:0]   probe_fc,
  output logic [ADDR_W-1:0] probe_status
);
  localparam int NWIN   = 4;
  localparam int FC_SUP = FC_W - 1;

  logic [WIN_W-1:0] win_q [NWIN];
  logic [NWIN-1:0]  we;
  always_comb we = {iwin1_we, iwin0_we, dwin1_we, dwin0_we};

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst)        win_q[g][EN_BIT] <= 1'b0;
      else if (we[g]) win_q[g]         <= wr_data;
    end
  end

  // access path
  logic [WIN_W-1:0] acc_w0, acc_w1;
  tt_res_e          acc_res;
  always_comb begin
    acc_w0 = acc_data ? win_q[0] : win_q[2];
    acc_w1 = acc_data ? win_q[1] : win_q[3];
  end
  tt_pair_lookup #(.ADDR_W(ADDR_W)) u_acc (
    .win0(acc_w0), .win1(acc_w1), .addr(acc_addr),
    .super_acc(acc_super), .res(acc_res));
  always_comb acc_result = acc_res;

  // probe path
  logic             prb_super, prb_data;
  logic [WIN_W-1:0] prb_w0, prb_w1;
  tt_res_e          prb_res;
  always_comb begin
    prb_super = probe_fc[FC_SUP];
    prb_data  = (probe_fc[1:0] != 2'd2);
    prb_w0    = prb_data ? win_q[0] : win_q[2];
    prb_w1    = prb_data ? win_q[1] : win_q[3];
  end
  tt_pair_lookup #(.ADDR_W(ADDR_W)) u_prb (
    .win0(prb_w0), .win1(prb_w1), .addr(probe_addr),
    .super_acc(prb_super), .res(prb_res));

  tt_probe #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) u_stat (
    .clk(clk), .rst(rst), .stb(probe_stb), .addr(probe_addr),
    .lookup(prb_res), .status(probe_status));

  // R4
  result_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    acc_result != 2'd3);
  // R9
  reset_disables_all_chk: assert property (@(posedge clk)
    rst |=> (win_q[0][EN_BIT] | win_q[1][EN_BIT] | win_q[2][EN_BIT] | win_q[3][EN_BIT]) == 1'b0);
endmodule

// File: tb/tt_matcher_bench.sv
module tt_matcher_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dwin0_we = 0, dwin1_we = 0, iwin0_we = 0, iwin1_we = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] acc_addr = '0;
  logic        acc_super = 0, acc_data = 0;
  logic [1:0]  acc_result;
  logic        probe_stb = 0;
  logic [31:0] probe_addr = '0;
  logic [2:0]  probe_fc = '0;
  logic [31:0] probe_status;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  tt_matcher u_tt_matcher (
    .clk(clk), .rst(rst),
    .dwin0_we(dwin0_we), .dwin1_we(dwin1_we), .iwin0_we(iwin0_we), .iwin1_we(iwin1_we),
    .wr_data(wr_data), .acc_addr(acc_addr), .acc_super(acc_super), .acc_data(acc_data),
    .acc_result(acc_result), .probe_stb(probe_stb), .probe_addr(probe_addr),
    .probe_fc(probe_fc), .probe_status(probe_status));

  // vector: {addr, super, data, expected result}
  localparam int NV = 10;
  localparam logic [35:0] VEC [NV] = '{
    {32'h4512_3456, 1'b0, 1'b1, 2'd1},  // R2 masked bits forgiven, R3 privilege ignored
    {32'h4000_0000, 1'b1, 1'b1, 2'd1},  // R5 window 0 hit
    {32'h5000_0000, 1'b1, 1'b1, 2'd2},  // R4 write-protected hit in window 1
    {32'h50AB_CDEF, 1'b0, 1'b1, 2'd0},  // R3 privilege mismatch
    {32'h5100_0000, 1'b1, 1'b1, 2'd0},  // R2 unmasked bit differs
    {32'h8000_0000, 1'b0, 1'b0, 2'd1},  // R6 instruction pair hit
    {32'h8000_0000, 1'b1, 1'b0, 2'd0},  // R3 user-only window, R1 iwin1 disabled
    {32'h4000_0000, 1'b0, 1'b0, 2'd0},  // R6 data windows unused for instructions
    {32'h8000_0000, 1'b0, 1'b1, 2'd0},  // R6 instruction windows unused for data
    {32'h4F00_0000, 1'b1, 1'b1, 2'd1}   // R2 all masked bits differ
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] v);
    @(negedge clk);
    wr_data = v;
    dwin0_we = (idx == 0); dwin1_we = (idx == 1);
    iwin0_we = (idx == 2); iwin1_we = (idx == 3);
    @(negedge clk);
    {dwin0_we, dwin1_we, iwin0_we, iwin1_we} = '0;
  endtask

  task automatic look(logic [31:0] a, logic s, logic d);
    acc_addr = a; acc_super = s; acc_data = d;
    #1;
  endtask

  task automatic probe(logic [31:0] a, logic [2:0] fc);
    @(negedge clk);
    probe_addr = a; probe_fc = fc; probe_stb = 1'b1;
    @(negedge clk);
    probe_stb = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R9 status after reset", probe_status, 32'h0);
    look(32'h4000_0000, 1'b1, 1'b1);
    check("R9 no match after reset", {30'd0, acc_result}, 32'd0);

    wr(0, 32'h400F_C000);
    wr(1, 32'h5000_A004);
    wr(2, 32'h8000_8000);
    wr(3, 32'h00FF_4000);

    for (int i = 0; i < NV; i++) begin
      look(VEC[i][35:4], VEC[i][3], VEC[i][2]);
      check($sformatf("R2/R3/R4/R5/R6 vector %0d", i), {30'd0, acc_result}, {30'd0, VEC[i][1:0]});
    end

    // R8 R7 probes
    probe(32'h8000_1ABC, 3'b010);
    check("R7 R8 user instruction probe hit", probe_status, 32'h8000_1003);
    probe(32'h8000_1ABC, 3'b110);
    check("R7 super instruction probe miss", probe_status, 32'h8000_1000);
    probe(32'h5000_2FFF, 3'b101);
    check("R8 R7 protected hit sets T and R", probe_status, 32'h5000_2003);
    probe(32'h5000_2FFF, 3'b001);
    check("R7 user data probe miss", probe_status, 32'h5000_2000);
    @(negedge clk);
    probe_addr = 32'hFFFF_FFFF; probe_fc = 3'b010;
    repeat (2) @(negedge clk);
    check("R8 status holds without strobe", probe_status, 32'h5000_2000);

    // R5 protected window 0 beats plain window 1
    wr(0, 32'h400F_C004);
    wr(1, 32'h4000_C000);
    look(32'h4000_0000, 1'b0, 1'b1);
    check("R5 window0 protected wins", {30'd0, acc_result}, 32'd2);
    look(32'h4F00_0000, 1'b0, 1'b1);
    check("R10 window0 reload applied", {30'd0, acc_result}, 32'd2);

    // R1 R10 enable iwin1
    look(32'h1234_5678, 1'b1, 1'b0);
    check("R1 disabled iwin1 no match", {30'd0, acc_result}, 32'd0);
    wr(3, 32'h00FF_C000);
    look(32'h1234_5678, 1'b1, 1'b0);
    check("R10 R1 enabled iwin1 matches", {30'd0, acc_result}, 32'd1);
    look(32'h8000_0000, 1'b0, 1'b0);
    check("R10 other window unchanged", {30'd0, acc_result}, 32'd1);

    // R9 mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R9 status cleared", probe_status, 32'h0);
    look(32'h1234_5678, 1'b1, 1'b0);
    check("R9 iwin1 disabled", {30'd0, acc_result}, 32'd0);
    look(32'h4000_0000, 1'b0, 1'b1);
    check("R9 dwin0 disabled", {30'd0, acc_result}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule